// File: doc/BRIEF.md
# Neutral Current Mismatch Detector

This block watches a three-phase current measurement for tampering or wiring faults. Each time a sample strobe arrives it takes one signed sample from each of the three phase-current channels and one from the neutral channel. It adds the phase samples into a 28-bit signed sum and stores that sum so software can read it. In a healthy installation the neutral current matches the sum of the phase currents. The block therefore takes the magnitude of the sum and the magnitude of the neutral sample, forms the absolute value of their difference, and compares it with a programmable threshold. A larger difference sets a sticky mismatch flag, and that flag can drive an active-low interrupt.

Software reaches the block through a small word-wide register port with four words: the sum readback, the threshold, the status word and the interrupt mask. Writes take effect on the clock edge. Reads are combinational from the address. The threshold resets to zero, and a zero or negative threshold makes every comparison trip. Software must therefore program a positive level after reset before the flag becomes useful.

Top module: `ncm_detector`

## Requirements
- R1: On the clock edge that samples `strobe_i` high, the stored sum becomes the 28-bit signed sum `ia_i + ib_i + ic_i`, and it keeps that value until the next strobe. Reading address 0 returns the sum in bits 27:0 (bit 27 is the sign) with bits 31:28 zero.
- R2: `drdy_o` is high for exactly the one cycle after the edge that sampled a strobe, and it is low in every other cycle.
- R3: One edge after a strobe edge, the block compares `abs(abs(sum) - abs(neutral))` from that strobe's samples with the threshold. If the value is strictly greater than the threshold, status bit 20 (read at address 2) becomes 1. An equal or smaller value leaves the flag unchanged.
- R4: A threshold of zero (the reset value) or any negative threshold sets the flag on every comparison.
- R5: A write to address 1 stores `wdata_i[23:0]` as a 24-bit signed threshold. Reading address 1 returns it sign-extended to 28 bits, with bits 31:28 zero.
- R6: The mismatch flag is sticky. A write to address 2 with bit 20 set clears it. A write to address 2 with bit 20 clear leaves it unchanged.
- R7: When a clearing write and a new mismatch fall on the same edge, the flag stays set.
- R8: A write to address 3 stores the interrupt enable from `wdata_i[20]`, which reads back at address 3 bit 20. `irq_no` is low exactly while both the flag and the enable are 1.
- R9: Magnitudes are computed without overflow, including the most negative sample on every channel.
- R10: After reset the sum, threshold, flag and enable are 0, `irq_no` is high and `drdy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample strobe, one cycle per sample set |
| ia_i | input | 24 | Phase A current sample, signed |
| ib_i | input | 24 | Phase B current sample, signed |
| ic_i | input | 24 | Phase C current sample, signed |
| in_i | input | 24 | Neutral current sample, signed |
| we_i | input | 1 | Register write enable |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from `addr_i` |
| drdy_o | output | 1 | New sum available pulse |
| irq_no | output | 1 | Mismatch interrupt, active low |

## Verification
The stored sum and `drdy_o` are due one edge after the strobe edge. The mismatch flag and `irq_no` are due on the edge after that, because the compare works from the registered sum. The bench drives every input on the falling edge. It checks the sum and `drdy_o` on the falling edge after the strobe edge, and it checks the flag and interrupt one falling edge later. Register writes are checked on the falling edge after they are latched, and the combinational reads are sampled a short delay after the address changes.

// File: rtl/ncm_pkg.sv
package ncm_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2;
  localparam int FLAG_BIT = 20;

  typedef enum logic [ADDR_W-1:0] {
    A_SUM  = 2'd0,
    A_THR  = 2'd1,
    A_STAT = 2'd2,
    A_MASK = 2'd3
  } reg_addr_e;

  localparam int N_PH = 3;
endpackage

// File: rtl/ncm_sum.sv
module ncm_sum #(
  parameter int SMP_W = 24,
  parameter int SUM_W = 28
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              strobe_i,
  input  logic [ncm_pkg::N_PH-1:0][SMP_W-1:0] ph_i,
  input  logic [SMP_W-1:0]                  neu_i,
  output logic [SUM_W-1:0]                  sum_o,
  output logic [SMP_W-1:0]                  neu_o,
  output logic                              vld_o
);
  localparam int NP = ncm_pkg::N_PH;

  logic signed [SUM_W-1:0] ext [NP];
  logic signed [SUM_W-1:0] acc [NP+1];

  assign acc[0] = '0;
  for (genvar g = 0; g < NP; g++) begin : g_ph
    assign ext[g]   = SUM_W'($signed(ph_i[g]));
    assign acc[g+1] = acc[g] + ext[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o <= '0;
      neu_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= strobe_i;
      if (strobe_i) begin
        sum_o <= acc[NP];
        neu_o <= neu_i;
      end
    end
  end

  p_sum_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(sum_o));
  p_vld_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> vld_o);
endmodule

// File: rtl/ncm_cmp.sv
module ncm_cmp #(
  parameter int SMP_W = 24,
  parameter int SUM_W = 28,
  parameter int THR_W = 24
) (
  input  logic             vld_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [SMP_W-1:0] neu_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             hit_o
);
  // one guard bit over the wider operand so |most negative| fits
  localparam int MAG_W = SUM_W + 1;
  localparam int DIF_W = MAG_W + 1;

  logic signed [MAG_W-1:0] s_ext, n_ext, mag_s, mag_n;
  logic signed [DIF_W-1:0] diff, adiff, thr_ext;
  logic                    thr_nonpos;

  always_comb begin
    s_ext   = MAG_W'($signed(sum_i));
    n_ext   = MAG_W'($signed(neu_i));
    mag_s   = s_ext[MAG_W-1] ? -s_ext : s_ext;
    mag_n   = n_ext[MAG_W-1] ? -n_ext : n_ext;
    diff    = DIF_W'(mag_s) - DIF_W'(mag_n);
    adiff   = diff[DIF_W-1] ? -diff : diff;
    thr_ext = DIF_W'($signed(thr_i));
    thr_nonpos = thr_ext <= 0;
    hit_o   = vld_i && (thr_nonpos || adiff > thr_ext);
  end

  p_mag_pos_r9: assert property (@(posedge vld_i)
    !mag_s[MAG_W-1] && !mag_n[MAG_W-1] && !adiff[DIF_W-1]);
endmodule

// File: rtl/ncm_regs.sv
module ncm_regs #(
  parameter int SUM_W = 28,
  parameter int THR_W = 24
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ncm_pkg::ADDR_W-1:0]  addr_i,
  input  logic [ncm_pkg::REG_W-1:0]   wdata_i,
  input  logic                        hit_i,
  input  logic [SUM_W-1:0]            sum_i,
  output logic [ncm_pkg::REG_W-1:0]   rdata_o,
  output logic [THR_W-1:0]            thr_o,
  output logic                        irq_no
);
  import ncm_pkg::*;

  logic             flag_q, mask_q, clr;
  logic [SUM_W-1:0] thr_rd;
  logic             wdata_unused;

  assign wdata_unused = ^{wdata_i[REG_W-1:FLAG_BIT+1], wdata_i[FLAG_BIT-1:THR_W]};
  assign clr = we_i && (addr_i == A_STAT) && wdata_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_o  <= '0;
      mask_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (we_i && addr_i == A_THR)  thr_o  <= wdata_i[THR_W-1:0];
      if (we_i && addr_i == A_MASK) mask_q <= wdata_i[FLAG_BIT];
      if (hit_i)    flag_q <= 1'b1;   // new event beats clear
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign thr_rd = SUM_W'($signed(thr_o));

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_SUM:  rdata_o = REG_W'(sum_i);
      A_THR:  rdata_o = REG_W'(thr_rd);
      A_STAT: rdata_o[FLAG_BIT] = flag_q;
      A_MASK: rdata_o[FLAG_BIT] = mask_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_no = !(flag_q && mask_q);

  p_hit_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> flag_q);
  p_hit_beats_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && clr) |=> flag_q);
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr) |=> flag_q);
  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_q |-> irq_no);
endmodule

// File: rtl/ncm_detector.sv
module ncm_detector #(
  parameter int SMP_W = 24,
  parameter int SUM_W = 28,
  parameter int THR_W = 24
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       strobe_i,
  input  logic [SMP_W-1:0]           ia_i,
  input  logic [SMP_W-1:0]           ib_i,
  input  logic [SMP_W-1:0]           ic_i,
  input  logic [SMP_W-1:0]           in_i,
  input  logic                       we_i,
  input  logic [ncm_pkg::ADDR_W-1:0] addr_i,
  input  logic [ncm_pkg::REG_W-1:0]  wdata_i,
  output logic [ncm_pkg::REG_W-1:0]  rdata_o,
  output logic                       drdy_o,
  output logic                       irq_no
);
  logic [ncm_pkg::N_PH-1:0][SMP_W-1:0] ph;
  logic [SUM_W-1:0] sum_q;
  logic [SMP_W-1:0] neu_q;
  logic [THR_W-1:0] thr;
  logic             vld_q, hit;

  assign ph = {ic_i, ib_i, ia_i};

  ncm_sum #(.SMP_W(SMP_W), .SUM_W(SUM_W)) i_sum (
    .clk_i, .rst_ni, .strobe_i,
    .ph_i(ph), .neu_i(in_i),
    .sum_o(sum_q), .neu_o(neu_q), .vld_o(vld_q)
  );

  ncm_cmp #(.SMP_W(SMP_W), .SUM_W(SUM_W), .THR_W(THR_W)) i_cmp (
    .vld_i(vld_q), .sum_i(sum_q), .neu_i(neu_q), .thr_i(thr), .hit_o(hit)
  );

  ncm_regs #(.SUM_W(SUM_W), .THR_W(THR_W)) i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .hit_i(hit), .sum_i(sum_q),
    .rdata_o, .thr_o(thr), .irq_no
  );

  assign drdy_o = vld_q;

  p_drdy_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !drdy_o);
  p_pad_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ncm_pkg::A_SUM) |-> (rdata_o[31:28] == 4'h0));
endmodule

// File: tb/test_ncm_detector.sv
module test_ncm_detector;
  logic        clk_i = 0, rst_ni = 0, strobe_i = 0, we_i = 0;
  logic [23:0] ia_i = 0, ib_i = 0, ic_i = 0, in_i = 0;
  logic [1:0]  addr_i = 0;
  logic [31:0] wdata_i = 0, rdata_o;
  logic        drdy_o, irq_no;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_thr = 0;
  bit m_flag = 0, m_mask = 0;
  longint m_sum = 0;

  ncm_detector i_ncm_detector (.*);

  always #5 clk_i = ~clk_i;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      report();
    end
  end

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic longint labs(longint v); return v < 0 ? -v : v; endfunction
  function automatic bit exp_hit(longint s, longint n, int t);
    return (t <= 0) || (labs(labs(s) - labs(n)) > t);
  endfunction
  function automatic longint s24(logic [23:0] v); return longint'($signed(v)); endfunction

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i); we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); we_i = 0; wdata_i = 0;
    if (a == 2'd1) m_thr = int'($signed(d[23:0]));
    if (a == 2'd3) m_mask = d[20];
    if (a == 2'd2 && d[20]) m_flag = 0;
  endtask

  task automatic check_flag(string req);
    logic [31:0] d;
    rd(2'd2, d); chk(req, d, {11'b0, m_flag, 20'b0});
    chk("R8 irq", irq_no, !(m_flag && m_mask));
  endtask

  task automatic strobe(input longint a, input longint b, input longint c,
                        input longint n, input bit clr_same);
    logic [31:0] d;
    @(negedge clk_i);
    ia_i = 24'(a); ib_i = 24'(b); ic_i = 24'(c); in_i = 24'(n); strobe_i = 1;
    @(negedge clk_i);
    strobe_i = 0;
    if (clr_same) begin we_i = 1; addr_i = 2'd2; wdata_i = 32'h0010_0000; end
    m_sum = a + b + c;
    chk("R2 drdy high", drdy_o, 1);
    if (!clr_same) begin
      rd(2'd0, d); chk("R1 sum", d, {4'b0, 28'(m_sum)});
    end
    @(negedge clk_i);
    we_i = 0; wdata_i = 0;
    chk("R2 drdy low", drdy_o, 0);
    if (clr_same) m_flag = 0;
    m_flag = m_flag | exp_hit(m_sum, n, m_thr);
    check_flag("R3 flag");
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2718));
    #12;
    // R10 reset state
    rd(2'd0, d); chk("R10 sum", d, 0);
    rd(2'd1, d); chk("R10 thr", d, 0);
    rd(2'd2, d); chk("R10 flag", d, 0);
    rd(2'd3, d); chk("R10 mask", d, 0);
    chk("R10 irq", irq_no, 1);
    chk("R10 drdy", drdy_o, 0);
    rst_ni = 1;

    // R4 zero threshold trips even on a perfect match
    strobe(100, 200, 300, 600, 0);
    chk("R4 zero thr", m_flag, 1);
    wr(2'd2, 32'h0000_0000);  // R6 write without bit 20
    check_flag("R6 no clear");
    wr(2'd2, 32'h0010_0000);
    check_flag("R6 clear");

    // R5 threshold readback, negative value
    wr(2'd1, 32'hFF80_0001);
    rd(2'd1, d); chk("R5 neg readback", d, 32'h0F80_0001);
    strobe(1, 1, 1, 3, 0);
    chk("R4 neg thr", m_flag, 1);
    wr(2'd2, 32'h0010_0000);
    wr(2'd1, 32'h0000_0100);
    rd(2'd1, d); chk("R5 pos readback", d, 32'h0000_0100);

    // R3 boundaries: equal does not trip, one more does
    strobe(1000, 0, 0, -744, 0);    // |1000-744|=256
    chk("R3 equal", m_flag, 0);
    strobe(1000, 0, 0, 743, 0);     // 257
    chk("R3 above", m_flag, 1);

    // R8 interrupt enable
    wr(2'd3, 32'h0010_0000);
    rd(2'd3, d); chk("R8 mask read", d, 32'h0010_0000);
    check_flag("R8 irq on");
    wr(2'd2, 32'h0010_0000);
    check_flag("R8 irq off");

    // R7 clear collides with new mismatch
    strobe(5000, 0, 0, 0, 1);
    chk("R7 hit wins", m_flag, 1);
    wr(2'd2, 32'h0010_0000);

    // R9 most negative samples
    wr(2'd1, 32'h0000_0010);
    strobe(-8388608, -8388608, -8388608, -8388608, 0);
    wr(2'd2, 32'h0010_0000);
    strobe(-8388608, 0, 0, -8388608, 0);
    chk("R9 extreme equal", m_flag, 0);

    // R1/R3 constrained random
    for (int i = 0; i < 300; i++) begin
      longint a, b, c, n;
      a = longint'($signed(22'($urandom)));
      b = longint'($signed(22'($urandom)));
      c = longint'($signed(22'($urandom)));
      n = ($urandom % 2) ? (a + b + c) : -(a + b + c);
      n = n + longint'($urandom % 4001) - 2000;
      if ($urandom % 8 == 0) wr(2'd1, (($urandom % 10) == 0) ? 32'hFFFF_FF00 : $urandom % 3000);
      if ($urandom % 4 == 0) wr(2'd3, $urandom);
      strobe(a, b, c, n, ($urandom % 10) == 0);
      if ($urandom % 3 == 0) wr(2'd2, 32'h0010_0000);
    end
    report();
  end
endmodule